// File: doc/BRIEF.md
# Little-Endian Load/Store Unit

This block is the data-memory stage of a 64-bit core. Each cycle it can take one request made of an operation code, an access size, a byte address and 64 bits of store data. It turns that request into byte accesses on a byte-addressed data memory. Stores place the low byte of the data at the lowest address. Loads collect the bytes from memory, put them in little-endian order and extend the result to 64 bits.

The memory model is part of the block, so the unit can be tested on its own. It is split into eight byte-wide banks. Byte address A lives in bank A mod 8, at row A div 8. Any access of up to eight bytes, aligned or not, therefore uses each bank at most once, and every access completes in a single cycle. Every location reads as zero until it is written. Alignment traps are not part of this block.

Top module: `lsu_le_top`

## Requirements
- R1: While `rst` is high at a clock edge, `ld_valid` and `ld_data` are 0 after that edge.
- R2: A load presented at clock edge N gives `ld_valid` high for exactly the cycle after edge N+1, with its result on `ld_data`. Back-to-back requests give one result per cycle. A load issued in the cycle right after a store sees the stored bytes.
- R3: A byte location that has never been written reads back as zero.
- R4: A doubleword store (`req_op`=2, `req_size`=2) to address a writes bit range [8k+7:8k] of the data to address a+k, for k = 0..7.
- R5: A byte store (`req_size`=0) writes only bits [7:0] of the data, to address a. All other bytes are left unchanged.
- R6: A word store (`req_size`=1) writes only bits [31:0], to addresses a..a+3. Bytes a+4..a+7 are left unchanged.
- R7: A byte load (`req_op`=1, `req_size`=0) returns the byte at a with bit 7 copied into bits 63..8.
- R8: A word load (`req_size`=1) returns bytes a..a+3 as bits 31..0, with bit 31 copied into bits 63..32.
- R9: A doubleword load (`req_size`=2) returns bytes a..a+7 unchanged as bits 63..0.
- R10: Any byte address is accepted, including accesses that cross an 8-byte boundary. These are handled byte by byte with the same result as an aligned access.
- R11: The following make no memory access and produce no load result: `req_op` 0 (idle) or 3 (reserved), and any request with `req_size` 3. While `ld_valid` is low, `ld_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 2 | 0 idle, 1 load, 2 store, 3 reserved (no access) |
| req_size | input | 2 | 0 byte, 1 word, 2 doubleword, 3 reserved (no access) |
| req_addr | input | ADDR_W | Byte address of the lowest byte accessed |
| req_wdata | input | DATA_W | Store data; low byte goes to the lowest address |
| ld_data | output | DATA_W | Registered, extended load result |
| ld_valid | output | 1 | One-cycle pulse when `ld_data` carries a new load result |

## Verification
- **Doubleword store, then byte loads at each end.** Reading back the lowest and highest byte shows whether byte order is little-endian or reversed.
- **Byte and word stores on top of a known doubleword pattern.** Reading the whole doubleword back shows whether bytes outside the access size were written.
- **Loads of values with and without the top bit set.** These separate sign extension from zero extension, at both byte and word size.
- **Unaligned accesses that straddle an 8-byte row.** These show whether the per-bank row increment and the lane rotation are correct.
- **Back-to-back requests, and no-access requests followed by a reload.** The back-to-back requests test pipeline timing and store-to-load forwarding. The no-access requests with live-looking addresses and data show whether idle or reserved codes leak into memory or onto `ld_valid`.

// File: rtl/lsu_le_pkg.sv
package lsu_le_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_RSVD  = 2'd3
  } lsu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } lsu_size_e;

  // Number of bytes touched by an access of the given size.
  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    case (lsu_size_e'(sz))
      SZ_BYTE:  size_bytes = 4'd1;
      SZ_WORD:  size_bytes = 4'd4;
      SZ_DWORD: size_bytes = 4'd8;
      default:  size_bytes = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
  import lsu_le_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 64,
  parameter int BANK_IDX = 0
) (
  input  logic [ADDR_W-1:0]                      addr,
  input  logic [1:0]                             size,
  input  logic                                   access,
  input  logic                                   is_store,
  input  logic [DATA_W-1:0]                      wdata,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]     row,
  output logic                                   en,
  output logic                                   we,
  output logic [7:0]                             wbyte
);
  localparam int BANKS  = DATA_W / 8;
  localparam int LANE_W = $clog2(BANKS);

  logic [LANE_W-1:0] k;       // byte offset within the access served by this bank
  logic [ADDR_W-1:0] byte_addr;

  always_comb begin
    k         = LANE_W'(BANK_IDX) - addr[LANE_W-1:0];
    byte_addr = addr + ADDR_W'(k);
    row       = byte_addr[ADDR_W-1:LANE_W];
    en        = access && ({1'b0, k} < size_bytes(size));
    we        = en && is_store;
    wbyte     = wdata[{k, 3'b000} +: 8];
  end

endmodule

// File: rtl/lsu_byte_bank.sv
module lsu_byte_bank #(
  parameter int ROW_W = 7
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wbyte,
  output logic [7:0]       rbyte
);
  localparam int DEPTH = 1 << ROW_W;

  logic [7:0] mem [0:DEPTH-1];

  // Power-up contents: every location reads as zero until written.
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wbyte;
      rbyte <= mem[row];
    end
  end

endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_le_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                vld_in,
  input  logic [1:0]                          size_in,
  input  logic [$clog2(DATA_W/8)-1:0]         lane_in,
  input  logic [DATA_W/8-1:0][7:0]            rd_bytes,
  output logic [DATA_W-1:0]                   ld_data,
  output logic                                ld_valid
);
  localparam int BANKS  = DATA_W / 8;
  localparam int LANE_W = $clog2(BANKS);

  logic [BANKS-1:0][7:0] ordered;
  logic [DATA_W-1:0]     extended;

  // Rotate bank outputs so byte k of the access lands in byte lane k.
  always_comb begin
    for (int k = 0; k < BANKS; k++) begin
      ordered[k] = rd_bytes[lane_in + LANE_W'(k)];
    end
  end

  always_comb begin
    case (lsu_size_e'(size_in))
      SZ_BYTE:  extended = {{(DATA_W-8){ordered[0][7]}}, ordered[0]};
      SZ_WORD:  extended = {{(DATA_W-32){ordered[3][7]}}, ordered[3], ordered[2],
                            ordered[1], ordered[0]};
      default:  extended = ordered;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= vld_in;
      if (vld_in) ld_data <= extended;
    end
  end

endmodule

// File: rtl/lsu_le_top.sv
module lsu_le_top
  import lsu_le_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_valid
);
  localparam int BANKS  = DATA_W / 8;
  localparam int LANE_W = $clog2(BANKS);
  localparam int ROW_W  = ADDR_W - LANE_W;

  logic                  size_ok;
  logic                  is_load;
  logic                  is_store;
  logic                  access;
  logic [BANKS-1:0][7:0] rd_bytes;

  logic                  s1_load;
  logic [1:0]            s1_size;
  logic [LANE_W-1:0]     s1_lane;

  always_comb begin
    size_ok  = lsu_size_e'(req_size) != SZ_RSVD;
    is_load  = size_ok && (lsu_op_e'(req_op) == OP_LOAD);
    is_store = size_ok && (lsu_op_e'(req_op) == OP_STORE);
    access   = is_load || is_store;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [ROW_W-1:0] row;
    logic             en;
    logic             we;
    logic [7:0]       wbyte;

    lsu_lane_map #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .BANK_IDX(b)
    ) u_map (
      .addr    (req_addr),
      .size    (req_size),
      .access  (access),
      .is_store(is_store),
      .wdata   (req_wdata),
      .row     (row),
      .en      (en),
      .we      (we),
      .wbyte   (wbyte)
    );

    lsu_byte_bank #(
      .ROW_W(ROW_W)
    ) u_bank (
      .clk  (clk),
      .en   (en),
      .we   (we),
      .row  (row),
      .wbyte(wbyte),
      .rbyte(rd_bytes[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_load <= 1'b0;
      s1_size <= 2'd0;
      s1_lane <= '0;
    end else begin
      s1_load <= is_load;
      s1_size <= req_size;
      s1_lane <= req_addr[LANE_W-1:0];
    end
  end

  lsu_load_align #(
    .DATA_W(DATA_W)
  ) u_align (
    .clk     (clk),
    .rst     (rst),
    .vld_in  (s1_load),
    .size_in (s1_size),
    .lane_in (s1_lane),
    .rd_bytes(rd_bytes),
    .ld_data (ld_data),
    .ld_valid(ld_valid)
  );

endmodule

// File: rtl/lsu_le_checker.sv
module lsu_le_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        req_op,
  input logic [1:0]        req_size,
  input logic [DATA_W-1:0] ld_data,
  input logic              ld_valid
);
  logic       p1_ld, p2_ld;
  logic [1:0] p1_sz, p2_sz;

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_ld <= 1'b0;
      p2_ld <= 1'b0;
      p1_sz <= 2'd0;
      p2_sz <= 2'd0;
    end else begin
      p1_ld <= (req_op == 2'd1) && (req_size != 2'd3);
      p2_ld <= p1_ld;
      p1_sz <= req_size;
      p2_sz <= p1_sz;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!ld_valid && ld_data == '0)); // R1

  AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    ld_valid == p2_ld); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |-> $stable(ld_data)); // R11

  AST_BYTE_SIGN: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && p2_sz == 2'd0) |-> ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}}); // R7

  AST_WORD_SIGN: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && p2_sz == 2'd1) |-> ld_data[DATA_W-1:32] == {(DATA_W-32){ld_data[31]}}); // R8

endmodule

bind lsu_le_top lsu_le_checker #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .req_op  (req_op),
  .req_size(req_size),
  .ld_data (ld_data),
  .ld_valid(ld_valid)
);

// File: tb/lsu_le_top_tb.sv
module lsu_le_top_tb;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    op, sz;
  logic [AW-1:0] addr;
  logic [63:0]   wd;
  logic [63:0]   ld_data;
  logic          ld_valid;

  int checks = 0;
  int errors = 0;

  logic [7:0] ref_mem [0:(1<<AW)-1];

  always #2 clk = ~clk;

  lsu_le_top #(.ADDR_W(AW), .DATA_W(64)) u_dut (
    .clk(clk), .rst(rst), .req_op(op), .req_size(sz), .req_addr(addr),
    .req_wdata(wd), .ld_data(ld_data), .ld_valid(ld_valid)
  );

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : (s == 2'd2) ? 8 : 0;
  endfunction

  function automatic logic [63:0] ref_load(input logic [1:0] s, input logic [AW-1:0] a);
    logic [63:0] r = '0;
    for (int k = 0; k < nbytes(s); k++) r[8*k +: 8] = ref_mem[AW'(a + AW'(k))];
    if (s == 2'd0) r = {{56{r[7]}}, r[7:0]};
    if (s == 2'd1) r = {{32{r[31]}}, r[31:0]};
    return r;
  endfunction

  task automatic expect64(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic do_store(input logic [1:0] s, input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    op = 2'd2; sz = s; addr = a; wd = d;
    for (int k = 0; k < nbytes(s); k++) ref_mem[AW'(a + AW'(k))] = d[8*k +: 8];
    @(negedge clk);
    op = 2'd0;
    expect64("R11 store gives no ld_valid", {63'd0, ld_valid}, 64'd0);
  endtask

  task automatic do_load(input logic [1:0] s, input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    op = 2'd1; sz = s; addr = a; wd = 64'hBAD0BAD0BAD0BAD0;
    @(negedge clk);
    op = 2'd0;
    expect64("R2 no ld_valid one cycle after load", {63'd0, ld_valid}, 64'd0);
    @(negedge clk);
    expect64("R2 ld_valid two cycles after load", {63'd0, ld_valid}, 64'd1);
    expect64(tag, ld_data, ref_load(s, a));
  endtask

  task automatic t_reset;
    @(negedge clk);
    expect64("R1 ld_valid in reset", {63'd0, ld_valid}, 64'd0);
    expect64("R1 ld_data in reset", ld_data, 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_unwritten;
    do_load(2'd2, 10'h040, "R3 unwritten doubleword");
    do_load(2'd0, 10'h3FF, "R3 unwritten byte");
    do_load(2'd1, 10'h1F2, "R3 unwritten word");
  endtask

  task automatic t_dword_order;
    do_store(2'd2, 10'h010, 64'h8877665544332211);
    do_load(2'd0, 10'h010, "R4 lowest address holds LSB");
    do_load(2'd0, 10'h017, "R4 R7 highest address holds MSB, sign extended");
    do_load(2'd2, 10'h010, "R9 doubleword unchanged");
    do_load(2'd0, 10'h011, "R4 second byte");
  endtask

  task automatic t_byte_store;
    do_store(2'd0, 10'h013, 64'hAABBCCDDEEFF0012);
    do_load(2'd2, 10'h010, "R5 byte store touches only one byte");
    do_store(2'd0, 10'h050, 64'h000000000000007F);
    do_load(2'd0, 10'h050, "R7 positive byte zero upper bits");
  endtask

  task automatic t_word_store;
    do_store(2'd2, 10'h020, 64'h1111111111111111);
    do_store(2'd1, 10'h020, 64'hDEADBEEF7ABCDEF0);
    do_load(2'd2, 10'h020, "R6 word store keeps upper bytes");
    do_load(2'd1, 10'h020, "R8 positive word");
    do_store(2'd1, 10'h028, 64'h0000000080000001);
    do_load(2'd1, 10'h028, "R8 negative word sign extended");
  endtask

  task automatic t_unaligned;
    do_store(2'd2, 10'h035, 64'h0123456789ABCDEF);
    do_load(2'd2, 10'h035, "R10 unaligned doubleword across row");
    do_load(2'd0, 10'h038, "R10 byte inside unaligned store");
    do_load(2'd1, 10'h037, "R10 unaligned word across row");
    do_store(2'd1, 10'h3FE, 64'h00000000CAFEF00D);
    do_load(2'd1, 10'h3FE, "R10 word wrapping past top address");
  endtask

  task automatic t_back_to_back;
    logic [63:0] e1, e2;
    // two consecutive loads
    @(negedge clk);
    op = 2'd1; sz = 2'd2; addr = 10'h010;
    e1 = ref_load(2'd2, 10'h010);
    @(negedge clk);
    sz = 2'd0; addr = 10'h017;
    e2 = ref_load(2'd0, 10'h017);
    @(negedge clk);
    op = 2'd0;
    expect64("R2 first pipelined valid", {63'd0, ld_valid}, 64'd1);
    expect64("R2 first pipelined data", ld_data, e1);
    @(negedge clk);
    expect64("R2 second pipelined valid", {63'd0, ld_valid}, 64'd1);
    expect64("R2 second pipelined data", ld_data, e2);
    // store followed at once by a load of the same address
    @(negedge clk);
    op = 2'd2; sz = 2'd2; addr = 10'h0A3; wd = 64'hF0E1D2C3B4A59687;
    for (int k = 0; k < 8; k++) ref_mem[AW'(10'h0A3 + AW'(k))] = wd[8*k +: 8];
    @(negedge clk);
    op = 2'd1; sz = 2'd2; addr = 10'h0A3;
    @(negedge clk);
    op = 2'd0;
    @(negedge clk);
    expect64("R2 load right after store valid", {63'd0, ld_valid}, 64'd1);
    expect64("R2 load right after store data", ld_data, ref_load(2'd2, 10'h0A3));
  endtask

  task automatic t_no_access;
    logic [63:0] prev;
    prev = ld_data;
    @(negedge clk);
    op = 2'd0; sz = 2'd2; addr = 10'h010; wd = 64'h5555555555555555;
    @(negedge clk);
    op = 2'd3;
    @(negedge clk);
    op = 2'd2; sz = 2'd3;
    @(negedge clk);
    op = 2'd1; sz = 2'd3;
    @(negedge clk);
    op = 2'd0; sz = 2'd0;
    expect64("R11 no ld_valid after idle/reserved", {63'd0, ld_valid}, 64'd0);
    @(negedge clk);
    expect64("R11 no ld_valid after reserved-size load", {63'd0, ld_valid}, 64'd0);
    expect64("R11 ld_data held", ld_data, prev);
    do_load(2'd2, 10'h010, "R11 memory unchanged by no-access requests");
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = 8'h00;
    rst = 1'b1; op = 2'd0; sz = 2'd0; addr = '0; wd = '0;
    repeat (3) @(posedge clk);
    t_reset();
    t_unwritten();
    t_dword_order();
    t_byte_store();
    t_word_store();
    t_unaligned();
    t_back_to_back();
    t_no_access();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule